// File: doc/BRIEF.md
# Charge Termination and Top-Off Timer Controller

This controller decides when a battery charge cycle is over. It watches digitized comparator and loop flags and decides from them whether the battery is full. The flags are battery voltage above the recharge level, constant-voltage mode active and battery current under the termination level. The enable bit and the three regulation-loop flags (input current, input voltage, thermal) gate the decision. When the full condition holds steadily, the cycle ends at once. If a top-off duration is selected, the cycle first passes through a timed top-off segment. The top-off counter is paced by an external timebase tick and follows the safety timer's pause and half-rate states.

The controller reports a 3-bit charge status code, a one-cycle interrupt pulse per event and a sticky, clear-on-read flag. It also raises a request to open the battery switch once charging is finished. A charge stop/restart event or a register reset returns it to charging. All pins are plain control and status levels or pulses. Nothing here moves a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `chg_term_ctrl`

## Requirements
- R1: After reset, chg_stat is 3'b011 (charging), and irq, chg_flag and batsw_off_req are 0.
- R2: Termination is accepted only after vbat_above_rechg, cv_active and ibat_below_term have all been high at 16 consecutive ticks. Any cycle with one of them low restarts the count, and the outputs change at the clock edge of the 16th tick.
- R3: While any of iin_reg_active, vin_reg_active or therm_reg_active is high, termination is not accepted.
- R4: While term_en is 0, termination never happens.
- R5: On termination with topoff_sel = 2'b00, chg_stat becomes 3'b111, one irq pulse is issued, batsw_off_req goes high and chg_flag is not set.
- R6: On termination with topoff_sel nonzero, chg_stat becomes 3'b110 with one irq pulse. After 15 x topoff_sel counted ticks, chg_stat becomes 3'b111 with a second irq pulse and batsw_off_req goes high. irq is never wider than one cycle.
- R7: While safety_suspend is high, the top-off count does not advance. While safety_half_rate is high, only every second tick counts.
- R8: topoff_sel is captured at termination. Changing it during top-off does not change the duration.
- R9: chg_flag is set on top-off entry and again on top-off expiry, and is cleared in the cycle after flag_rd is high. If a set and a read fall in the same cycle, the set wins.
- R10: A high chg_restart or reg_reset returns chg_stat to 3'b011, drops batsw_off_req and clears the qualifier and the top-off counter. The next cycle captures a fresh topoff_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase tick, one cycle per unit |
| vbat_above_rechg | input | 1 | Battery voltage above recharge level |
| cv_active | input | 1 | Constant-voltage regulation active |
| ibat_below_term | input | 1 | Battery current below termination level |
| iin_reg_active | input | 1 | Input-current regulation active |
| vin_reg_active | input | 1 | Input-voltage regulation active |
| therm_reg_active | input | 1 | Thermal regulation active |
| term_en | input | 1 | Termination enable |
| chg_restart | input | 1 | Charge stop/restart event |
| reg_reset | input | 1 | Register reset request |
| topoff_sel | input | 2 | Top-off duration code: 0 off, n = 15n ticks |
| safety_suspend | input | 1 | Safety timer paused |
| safety_half_rate | input | 1 | Safety timer at half rate |
| flag_rd | input | 1 | Read strobe that clears chg_flag |
| chg_stat | output | 3 | Charge status code |
| irq | output | 1 | One-cycle interrupt pulse |
| chg_flag | output | 1 | Sticky charge event flag |
| batsw_off_req | output | 1 | Request to open the battery switch |

## Verification
The flag has a setting event and a clearing read, and the two can land on the same clock edge. The bench provokes this by raising flag_rd on the very cycle that carries the 16th qualifying tick, so top-off entry and the read collide. The set must win and chg_flag must read 1 afterwards. A scoreboard checks each interrupt against the status code and switch request expected when it fires.

// File: rtl/chg_term_pkg.sv
package chg_term_pkg;
  typedef enum logic [1:0] {PH_CHARGE, PH_TOPOFF, PH_DONE} phase_t;

  localparam logic [2:0] STAT_CHARGE = 3'b011;
  localparam logic [2:0] STAT_TOPOFF = 3'b110;
  localparam logic [2:0] STAT_DONE   = 3'b111;

  function automatic logic [2:0] phase_code(phase_t p);
    case (p)
      PH_TOPOFF: return STAT_TOPOFF;
      PH_DONE:   return STAT_DONE;
      default:   return STAT_CHARGE;
    endcase
  endfunction
endpackage

// File: rtl/term_qualifier.sv
module term_qualifier #(
  parameter int QUAL_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic tick,
  input  logic vbat_hi,
  input  logic cv_act,
  input  logic ibat_lo,
  input  logic iin_reg,
  input  logic vin_reg,
  input  logic therm_reg,
  input  logic term_en,
  output logic term_det
);
  localparam int QW = $clog2(QUAL_TICKS + 1);

  logic          qual;
  logic [QW-1:0] cnt;

  assign qual = vbat_hi && cv_act && ibat_lo && term_en &&
                !iin_reg && !vin_reg && !therm_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr || !arm || !qual) cnt <= '0;
    else if (tick)               cnt <= cnt + 1'b1;
  end

  assign term_det = arm && !clr && qual && tick && (cnt == QW'(QUAL_TICKS - 1));

  // R2
  cnt_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $past(qual));
endmodule

// File: rtl/topoff_timer.sv
module topoff_timer #(
  parameter int UNIT_TICKS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       start,
  input  logic [1:0] sel_in,
  input  logic       run,
  input  logic       tick,
  input  logic       susp,
  input  logic       half,
  output logic       expire
);
  localparam int TW = $clog2(UNIT_TICKS * 3 + 1);

  logic [1:0]    sel_q;
  logic [TW-1:0] cnt;
  logic [TW-1:0] limit;
  logic          ph;
  logic          step;
  logic          adv;

  assign limit = TW'(UNIT_TICKS * int'(sel_q));
  assign step  = run && tick && !susp;
  assign adv   = step && (!half || ph);
  assign expire = adv && !clr && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt   <= '0;
      ph    <= 1'b0;
    end else if (clr || start) begin
      if (start && !clr) sel_q <= sel_in;
      cnt <= '0;
      ph  <= 1'b0;
    end else begin
      if (step && half) ph <= ~ph;
      if (adv) cnt <= cnt + 1'b1;
    end
  end

  // R7
  paused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && susp && !clr && !start) |=> $stable(cnt));
  // R8
  sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !start) |=> $stable(sel_q));
endmodule

// File: rtl/chg_term_ctrl.sv
module chg_term_ctrl
  import chg_term_pkg::*;
#(
  parameter int QUAL_TICKS = 16,
  parameter int UNIT_TICKS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       vbat_above_rechg,
  input  logic       cv_active,
  input  logic       ibat_below_term,
  input  logic       iin_reg_active,
  input  logic       vin_reg_active,
  input  logic       therm_reg_active,
  input  logic       term_en,
  input  logic       chg_restart,
  input  logic       reg_reset,
  input  logic [1:0] topoff_sel,
  input  logic       safety_suspend,
  input  logic       safety_half_rate,
  input  logic       flag_rd,
  output logic [2:0] chg_stat,
  output logic       irq,
  output logic       chg_flag,
  output logic       batsw_off_req
);
  phase_t phase;
  logic   clr, term_det, expire, flag_set;

  assign clr = chg_restart || reg_reset;

  term_qualifier #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr(clr), .arm(phase == PH_CHARGE), .tick(tick),
    .vbat_hi(vbat_above_rechg), .cv_act(cv_active), .ibat_lo(ibat_below_term),
    .iin_reg(iin_reg_active), .vin_reg(vin_reg_active), .therm_reg(therm_reg_active),
    .term_en(term_en), .term_det(term_det)
  );

  topoff_timer #(.UNIT_TICKS(UNIT_TICKS)) u_topoff (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(term_det), .sel_in(topoff_sel),
    .run(phase == PH_TOPOFF), .tick(tick), .susp(safety_suspend),
    .half(safety_half_rate), .expire(expire)
  );

  assign flag_set = (term_det && topoff_sel != 2'b00) || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CHARGE;
      irq      <= 1'b0;
      chg_flag <= 1'b0;
    end else begin
      irq <= !clr && (term_det || expire);
      if (flag_set)     chg_flag <= 1'b1;
      else if (flag_rd) chg_flag <= 1'b0;
      if (clr)
        phase <= PH_CHARGE;
      else if (term_det)
        phase <= (topoff_sel == 2'b00) ? PH_DONE : PH_TOPOFF;
      else if (expire)
        phase <= PH_DONE;
    end
  end

  assign chg_stat      = phase_code(phase);
  assign batsw_off_req = (phase == PH_DONE);

  // R3
  leave_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_CHARGE && phase != PH_CHARGE) |->
      $past(term_en && !iin_reg_active && !vin_reg_active && !therm_reg_active &&
            vbat_above_rechg && cv_active && ibat_below_term));
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R9
  flag_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TOPOFF && $past(phase) == PH_CHARGE) |-> chg_flag);
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_restart || reg_reset) |=> (chg_stat == STAT_CHARGE && !batsw_off_req));
endmodule

// File: tb/chg_term_ctrl_bench.sv
module chg_term_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, vbat = 0, cv = 0, ibat = 0, iin = 0, vin = 0, therm = 0;
  logic term_en = 1, restart = 0, rreset = 0, susp = 0, half = 0, flag_rd = 0;
  logic [1:0] sel = 2'b00;
  logic [2:0] chg_stat;
  logic irq, chg_flag, batsw;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] stat;
    logic       sw;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  chg_term_ctrl u_chg_term_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vbat_above_rechg(vbat),
    .cv_active(cv), .ibat_below_term(ibat), .iin_reg_active(iin),
    .vin_reg_active(vin), .therm_reg_active(therm), .term_en(term_en),
    .chg_restart(restart), .reg_reset(rreset), .topoff_sel(sel),
    .safety_suspend(susp), .safety_half_rate(half), .flag_rd(flag_rd),
    .chg_stat(chg_stat), .irq(irq), .chg_flag(chg_flag), .batsw_off_req(batsw)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [2:0] s, logic w, string tag);
    exp_t e;
    e.stat = s; e.sw = w; e.tag = tag;
    expq.push_back(e);
  endtask

  // monitor: every interrupt pops one expected record
  always @(negedge clk) begin
    if (rst_n && irq) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected irq actual stat=%0h expected none", chg_stat);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (chg_stat !== e.stat || batsw !== e.sw) begin
          errors++;
          $display("FAIL %s irq actual stat=%0h sw=%0b expected stat=%0h sw=%0b",
                   e.tag, chg_stat, batsw, e.stat, e.sw);
        end
      end
    end
  end

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_restart();
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  task automatic read_flag();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 stat", chg_stat, 3'b011);
    chk("R1 irq", irq, 0);
    chk("R1 flag", chg_flag, 0);
    chk("R1 batsw", batsw, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R5: 16 steady ticks, no top-off
    vbat = 1; cv = 1; ibat = 1;
    ticks(15);
    chk("R2 before 16th tick", chg_stat, 3'b011);
    push(3'b111, 1'b1, "R5");
    ticks(1);
    chk("R5 stat", chg_stat, 3'b111);
    chk("R5 batsw", batsw, 1);
    chk("R5 no flag", chg_flag, 0);
    pulse_restart();
    chk("R10 restart stat", chg_stat, 3'b011);
    chk("R10 restart batsw", batsw, 0);

    // R2: a dropout restarts the count
    ticks(10);
    @(negedge clk); cv = 0;
    @(negedge clk); cv = 1;
    ticks(15);
    chk("R2 count restarted", chg_stat, 3'b011);
    push(3'b111, 1'b1, "R2");
    ticks(1);
    chk("R2 terminated", chg_stat, 3'b111);
    pulse_restart();

    // R3: each regulation loop blocks
    iin = 1; ticks(20); chk("R3 iin blocks", chg_stat, 3'b011); iin = 0;
    vin = 1; ticks(20); chk("R3 vin blocks", chg_stat, 3'b011); vin = 0;
    therm = 1; ticks(20); chk("R3 therm blocks", chg_stat, 3'b011); therm = 0;

    // R4
    term_en = 0; ticks(20); chk("R4 disabled", chg_stat, 3'b011); term_en = 1;

    // R6 / R9: top-off of 15 ticks
    sel = 2'b01;
    push(3'b110, 1'b0, "R6 entry");
    ticks(16);
    chk("R6 topoff stat", chg_stat, 3'b110);
    chk("R9 flag on entry", chg_flag, 1);
    read_flag();
    chk("R9 flag cleared", chg_flag, 0);
    ticks(14);
    chk("R6 before expiry", chg_stat, 3'b110);
    push(3'b111, 1'b1, "R6 expiry");
    ticks(1);
    chk("R6 expired", chg_stat, 3'b111);
    chk("R9 flag on expiry", chg_flag, 1);
    read_flag();
    pulse_restart();

    // R7 half rate
    push(3'b110, 1'b0, "R7 entry");
    ticks(16);
    half = 1;
    ticks(29);
    chk("R7 half rate pending", chg_stat, 3'b110);
    push(3'b111, 1'b1, "R7 half expiry");
    ticks(1);
    chk("R7 half rate expired", chg_stat, 3'b111);
    half = 0;
    pulse_restart();

    // R7 suspend
    push(3'b110, 1'b0, "R7 entry2");
    ticks(16);
    ticks(5);
    susp = 1; ticks(20);
    chk("R7 suspended", chg_stat, 3'b110);
    susp = 0;
    ticks(9);
    chk("R7 resumed pending", chg_stat, 3'b110);
    push(3'b111, 1'b1, "R7 suspend expiry");
    ticks(1);
    chk("R7 resumed expired", chg_stat, 3'b111);
    pulse_restart();

    // R8 latch
    sel = 2'b10;
    push(3'b110, 1'b0, "R8 entry");
    ticks(16);
    sel = 2'b01;
    ticks(15);
    chk("R8 new sel ignored", chg_stat, 3'b110);
    ticks(14);
    chk("R8 still running", chg_stat, 3'b110);
    push(3'b111, 1'b1, "R8 expiry");
    ticks(1);
    chk("R8 30 ticks", chg_stat, 3'b111);
    pulse_restart();
    push(3'b110, 1'b0, "R10 entry");
    ticks(16);
    ticks(14);
    push(3'b111, 1'b1, "R10 fresh sel");
    ticks(1);
    chk("R10 fresh sel used", chg_stat, 3'b111);
    read_flag();
    pulse_restart();

    // R9 collision: read strobe on the entry edge
    ticks(15);
    push(3'b110, 1'b0, "R9 collide");
    @(negedge clk); tick = 1; flag_rd = 1;
    @(negedge clk); tick = 0; flag_rd = 0;
    chk("R9 set wins", chg_flag, 1);

    // R10 register reset during top-off
    @(negedge clk); rreset = 1;
    @(negedge clk); rreset = 0;
    chk("R10 reg reset stat", chg_stat, 3'b011);
    chk("R10 reg reset batsw", batsw, 0);

    repeat (3) @(negedge clk);
    chk("R6 all irqs seen", 8'(expq.size()), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule